// File: doc/BRIEF.md
# DMA Read-Back Sequencer

This block drives the read side of a DMA controller's processor port. A 7-bit selection mask chooses which of seven byte-wide sources are shown to the processor: the live status byte, the two halves of the current transfer count, and the two halves of each port address. When a refill is requested, the selected sources are captured together into a small buffer. They are packed into consecutive slots, lowest mask bit first. Each processor read then returns the slot under a read pointer, and the pointer steps forward and wraps back to the first slot.

The block also keeps two active-low event flags, match and end-of-block, and builds the live status byte from them and from the ready and interrupt-pending inputs. While the buffer is empty, a read returns the live status byte. A refill can be started by a plain refill command, by a mask write, or by a status command. The status command forces a mask that selects only the status byte. The counter and address generators that supply the count and address values live outside this block.

Top module: `dma_readback`

## Requirements
- R1: The status byte has bit 1 = NOT `ready`, bit 3 = NOT `irq_pending`, bit 4 = match flag, bit 5 = end-of-block flag. Bits 0, 2, 6 and 7 read 0.
- R2: A `set_match` pulse clears status bit 4 and a `set_eob` pulse clears status bit 5 from the next cycle. A set in the same cycle as `cmd_reinit` wins over it.
- R3: After reset both flags are 1, the mask is 0 and the buffer is empty. `cmd_reinit` returns both flags to 1.
- R4: On a refill, each set mask bit k (0 = status, 1 = count low, 2 = count high, 3 = port A low, 4 = port A high, 5 = port B low, 6 = port B high) adds its source byte. Bytes are stored in ascending k, and the buffer length equals the number of set bits.
- R5: With a non-empty buffer, `rd_data` shows the slot under the pointer. Each `rd_en` cycle moves the pointer to the next slot, and after the last slot it returns to the first.
- R6: With an empty buffer, including after a refill with a zero mask, `rd_data` equals the live status byte and `rd_en` has no effect.
- R7: `cmd_status` sets the mask to 7'h01 and refills, so the buffer then holds only a status-byte snapshot.
- R8: Buffered bytes are the values present on the clock edge of the refill. They do not follow later changes of the sources or flags.
- R9: `mask_wr` stores `mask_in` and refills with it in the same cycle. When several requests coincide, `cmd_status` wins over `mask_wr`, which wins over `cmd_refill`. Any refill resets the pointer to the first slot and overrides a coincident read step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_refill | input | 1 | Refill the buffer using the stored mask |
| cmd_status | input | 1 | Force the mask to status-only and refill |
| cmd_reinit | input | 1 | Return both event flags to 1 |
| mask_wr | input | 1 | Store `mask_in` and refill |
| mask_in | input | 7 | New selection mask |
| set_match | input | 1 | Match event, clears status bit 4 |
| set_eob | input | 1 | End-of-block event, clears status bit 5 |
| ready | input | 1 | Ready request active |
| irq_pending | input | 1 | Interrupt request pending |
| byte_count | input | 16 | Current transfer count |
| addr_a | input | 16 | Current port A address |
| addr_b | input | 16 | Current port B address |
| rd_en | input | 1 | Processor read strobe, advances the pointer |
| rd_data | output | 8 | Byte presented to the processor |

## Verification
The bench targets the wrap from the last slot back to the first. A design that got it wrong would run off the buffer end or return stale bytes. It also targets refills with a zero mask, which must fall back to live status rather than replay an old buffer. Coincident refill requests and reads are driven to catch a wrong priority, which would store the wrong mask or leave the pointer mid-buffer. Source and flag values are changed during read-out to catch a buffer that follows live values instead of holding its snapshot. Flag set and reinit pulses arriving together are exercised, because a wrong priority there silently loses a match or end-of-block event.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SRC_N  = 7;
  localparam int CNT_W  = $clog2(SRC_N + 1);
  localparam int STAT_RDY_BIT   = 1;
  localparam int STAT_IRQ_BIT   = 3;
  localparam int STAT_MATCH_BIT = 4;
  localparam int STAT_EOB_BIT   = 5;
  localparam logic [SRC_N-1:0] STATUS_ONLY_MASK = 7'h01;
  typedef logic [BYTE_W-1:0] rb_byte_t;
endpackage

// File: rtl/rb_status.sv
module rb_status
  import dma_rb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_match,
  input  logic     set_eob,
  input  logic     reinit,
  input  logic     ready,
  input  logic     irq_pending,
  output rb_byte_t status_byte
);
  logic match_n_q, match_n_d;
  logic eob_n_q, eob_n_d;
  logic flag_en;

  assign flag_en = set_match | set_eob | reinit;

  always_comb begin
    match_n_d = match_n_q;
    eob_n_d   = eob_n_q;
    if (reinit) begin
      match_n_d = 1'b1;
      eob_n_d   = 1'b1;
    end
    if (set_match) match_n_d = 1'b0;
    if (set_eob)   eob_n_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_n_q <= 1'b1;
      eob_n_q   <= 1'b1;
    end else if (flag_en) begin
      match_n_q <= match_n_d;
      eob_n_q   <= eob_n_d;
    end
  end

  always_comb begin
    status_byte                 = '0;
    status_byte[STAT_RDY_BIT]   = ~ready;
    status_byte[STAT_IRQ_BIT]   = ~irq_pending;
    status_byte[STAT_MATCH_BIT] = match_n_q;
    status_byte[STAT_EOB_BIT]   = eob_n_q;
  end

  p_match_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_match |=> !status_byte[STAT_MATCH_BIT]);
  p_eob_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_eob |=> !status_byte[STAT_EOB_BIT]);
  p_reinit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit && !set_match && !set_eob) |=>
      (status_byte[STAT_MATCH_BIT] && status_byte[STAT_EOB_BIT]));
endmodule

// File: rtl/rb_pack.sv
module rb_pack
  import dma_rb_pkg::*;
(
  input  logic [SRC_N-1:0]        mask,
  input  logic [SRC_N*BYTE_W-1:0] src_flat,
  output logic [SRC_N*BYTE_W-1:0] packed_flat,
  output logic [CNT_W-1:0]        fill_cnt
);
  always_comb begin
    logic [CNT_W-1:0] pos;
    pos         = '0;
    packed_flat = '0;
    for (int k = 0; k < SRC_N; k++) begin
      if (mask[k]) begin
        packed_flat[pos*BYTE_W +: BYTE_W] = src_flat[k*BYTE_W +: BYTE_W];
        pos = pos + 1'b1;
      end
    end
    fill_cnt = pos;
  end
endmodule

// File: rtl/rb_buffer.sv
module rb_buffer
  import dma_rb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [SRC_N*BYTE_W-1:0] load_data,
  input  logic [CNT_W-1:0]        load_cnt,
  input  logic                    rd_en,
  input  rb_byte_t                live_status,
  output rb_byte_t                rd_data
);
  logic [SRC_N*BYTE_W-1:0] store_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        ptr_q, ptr_d;
  logic                    ptr_en;
  logic                    step;

  assign step   = rd_en && (cnt_q != '0);
  assign ptr_en = load | step;

  always_comb begin
    ptr_d = ptr_q;
    if (load)                           ptr_d = '0;
    else if (step && (ptr_q + 1'b1 == cnt_q)) ptr_d = '0;
    else if (step)                      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      store_q <= load_data;
      cnt_q   <= load_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign rd_data = (cnt_q == '0) ? live_status : store_q[ptr_q*BYTE_W +: BYTE_W];

  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (ptr_q < cnt_q));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && rd_en && cnt_q != '0 && ptr_q + 1'b1 == cnt_q) |=> (ptr_q == '0));
  p_load_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr_q == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(store_q) && $stable(cnt_q)));
endmodule

// File: rtl/dma_readback.sv
module dma_readback
  import dma_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_refill,
  input  logic              cmd_status,
  input  logic              cmd_reinit,
  input  logic              mask_wr,
  input  logic [SRC_N-1:0]  mask_in,
  input  logic              set_match,
  input  logic              set_eob,
  input  logic              ready,
  input  logic              irq_pending,
  input  logic [WORD_W-1:0] byte_count,
  input  logic [WORD_W-1:0] addr_a,
  input  logic [WORD_W-1:0] addr_b,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data
);
  rb_byte_t                status_byte;
  logic [SRC_N-1:0]        mask_q, mask_d;
  logic                    mask_en;
  logic                    refill;
  logic [SRC_N*BYTE_W-1:0] src_flat;
  logic [SRC_N*BYTE_W-1:0] packed_flat;
  logic [CNT_W-1:0]        fill_cnt;

  rb_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_match   (set_match),
    .set_eob     (set_eob),
    .reinit      (cmd_reinit),
    .ready       (ready),
    .irq_pending (irq_pending),
    .status_byte (status_byte)
  );

  assign mask_en = cmd_status | mask_wr;
  assign refill  = cmd_status | mask_wr | cmd_refill;

  always_comb begin
    if (cmd_status)   mask_d = STATUS_ONLY_MASK;
    else if (mask_wr) mask_d = mask_in;
    else              mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign src_flat = {addr_b, addr_a, byte_count, status_byte};

  rb_pack u_pack (
    .mask        (mask_d),
    .src_flat    (src_flat),
    .packed_flat (packed_flat),
    .fill_cnt    (fill_cnt)
  );

  rb_buffer u_buffer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (refill),
    .load_data   (packed_flat),
    .load_cnt    (fill_cnt),
    .rd_en       (rd_en),
    .live_status (status_byte),
    .rd_data     (rd_data)
  );

  p_status_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status |=> (mask_q == STATUS_ONLY_MASK));
  p_mask_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !cmd_status) |=> (mask_q == $past(mask_in)));
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr && !cmd_status) |=> $stable(mask_q));
endmodule

// File: tb/test_dma_readback.sv
module test_dma_readback;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_refill, cmd_status, cmd_reinit, mask_wr;
  logic [6:0]  mask_in;
  logic        set_match, set_eob, ready, irq_pending, rd_en;
  logic [15:0] byte_count, addr_a, addr_b;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic       m_match_n, m_eob_n;
  logic [6:0] m_mask;
  logic [7:0] m_buf [7];
  int         m_cnt, m_ptr;

  always #2 clk = ~clk;

  dma_readback i_dma_readback (
    .clk(clk), .rst_n(rst_n), .cmd_refill(cmd_refill), .cmd_status(cmd_status),
    .cmd_reinit(cmd_reinit), .mask_wr(mask_wr), .mask_in(mask_in),
    .set_match(set_match), .set_eob(set_eob), .ready(ready),
    .irq_pending(irq_pending), .byte_count(byte_count), .addr_a(addr_a),
    .addr_b(addr_b), .rd_en(rd_en), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_status();
    return {2'b00, m_eob_n, m_match_n, ~irq_pending, 1'b0, ~ready, 1'b0};
  endfunction

  function automatic logic [7:0] exp_out();
    if (m_cnt == 0) return exp_status();
    return m_buf[m_ptr];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: rd_data actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_refill(logic [6:0] msk);
    logic [7:0] src [7];
    src[0] = exp_status();
    src[1] = byte_count[7:0];  src[2] = byte_count[15:8];
    src[3] = addr_a[7:0];      src[4] = addr_a[15:8];
    src[5] = addr_b[7:0];      src[6] = addr_b[15:8];
    m_cnt = 0;
    for (int k = 0; k < 7; k++)
      if (msk[k]) begin
        m_buf[m_cnt] = src[k];
        m_cnt++;
      end
    m_ptr = 0;
  endtask

  task automatic cycle(string tag);
    #1;
    check(tag, rd_data, exp_out());
    if (cmd_status)      begin m_mask = 7'h01;   model_refill(m_mask); end
    else if (mask_wr)    begin m_mask = mask_in; model_refill(m_mask); end
    else if (cmd_refill) model_refill(m_mask);
    else if (rd_en && m_cnt != 0) m_ptr = (m_ptr + 1 == m_cnt) ? 0 : m_ptr + 1;
    if (cmd_reinit) begin m_match_n = 1'b1; m_eob_n = 1'b1; end
    if (set_match) m_match_n = 1'b0;
    if (set_eob)   m_eob_n   = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cmd_refill = 0; cmd_status = 0; cmd_reinit = 0; mask_wr = 0; mask_in = '0;
    set_match = 0; set_eob = 0; rd_en = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    ready = 0; irq_pending = 0;
    byte_count = 16'h1234; addr_a = 16'h5678; addr_b = 16'h9abc;
    m_match_n = 1; m_eob_n = 1; m_mask = '0; m_cnt = 0; m_ptr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 check("R3", rd_data, 8'h3a);
    @(negedge clk);
    ready = 1; irq_pending = 1;
    #1 check("R1", rd_data, 8'h30);
    @(negedge clk);
    rd_en = 1; cycle("R6");
    idle(); mask_wr = 1; mask_in = 7'h7f; cycle("R6");
    idle(); rd_en = 1;
    byte_count = 16'hffff; addr_a = 16'h0; ready = 0;
    for (int i = 0; i < 9; i++) cycle(i == 0 ? "R4" : "R8");
    rd_en = 0; set_match = 1; cycle("R5");
    idle(); cycle("R2");
    set_eob = 1; cmd_reinit = 1; cycle("R2");
    idle(); cmd_reinit = 1; cycle("R2");
    idle(); cycle("R3");
    cmd_status = 1; mask_wr = 1; mask_in = 7'h2a; rd_en = 1; cycle("R9");
    idle(); cycle("R7");
    rd_en = 1; cycle("R7");
    idle(); mask_wr = 1; mask_in = 7'h0; cycle("R9");
    idle(); rd_en = 1; cycle("R6");
    idle(); mask_wr = 1; mask_in = 7'h50; cmd_refill = 1; cycle("R9");
    idle(); rd_en = 1; cycle("R9"); cycle("R5"); cycle("R5");
    cmd_refill = 1; cycle("R9");
    idle(); cycle("R9");
    for (int i = 0; i < 3000; i++) begin
      cmd_status = ($urandom_range(99) < 3);
      mask_wr    = ($urandom_range(99) < 8);
      mask_in    = 7'($urandom);
      cmd_refill = ($urandom_range(99) < 8);
      cmd_reinit = ($urandom_range(99) < 6);
      set_match  = ($urandom_range(99) < 5);
      set_eob    = ($urandom_range(99) < 5);
      rd_en      = ($urandom_range(99) < 55);
      ready      = 1'($urandom);
      irq_pending = 1'($urandom);
      byte_count = 16'($urandom);
      addr_a     = 16'($urandom);
      addr_b     = 16'($urandom);
      cycle(m_cnt == 0 ? "R6" : "R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule